// File: doc/BRIEF.md
# Sector Buffer Host Transfer Engine

This block drains decoded sector bytes out of a local byte buffer toward whichever agent asked for them. It keeps a 16-bit byte count and a 16-bit source address. In host mode, one of two processors pulls 16-bit words through a data port, one word per read strobe. In DMA mode, each step request copies a chunk of words into a program memory, a work memory, or a discard sink. The work memory has two layouts, a full-bank layout and an interleaved half-bank layout.

When the count runs out, the engine ends the transfer. It raises the end flag, drops the data-ready flag and releases its busy indication. It also lowers an active-low end-of-transfer interrupt flag and pulses an interrupt request. Each of these interrupt actions depends on its own enable. The buffer is read combinationally: the block presents a byte address and receives the byte at that address and the byte at the next address.

Top module: `sxe_engine`

## Requirements
- R1: After reset, busy_n=1, irq_flag_n=1, end_flag=0, data_ready=0, xfer_active=0, byte_count=0, irq_req=0 and dst_we=0.
- R2: A start pulse begins a transfer only while the stored transfer-enable is 1. Starting sets xfer_active=1, busy_n=0 and end_flag=0. A start while the enable is 0 changes none of these outputs.
- R3: A control write with transfer-enable 0 aborts. In the next cycle byte_count=0, xfer_active=0 and busy_n=1.
- R4: A host read is honoured only while xfer_active=1, and only for the matching destination code: rd_sub needs dest_sel=3 and rd_main needs dest_sel=2. A refused read returns host_data=0 and leaves byte_count and buf_addr unchanged.
- R5: An honoured read returns {byte at buf_addr, byte at buf_addr+1}, with the lower-addressed byte in bits 15:8. It reduces byte_count by 2 and advances buf_addr by 2.
- R6: An honoured read that finds byte_count at 2 or less ends the transfer. The same word is still returned. Ending forces byte_count=0, xfer_active=0, end_flag=1, data_ready=0 and busy_n=1. data_ready is set only by rdy_set.
- R7: On end of transfer, irq_flag_n goes to 0 only if the stored end-interrupt enable is 1. irq_req is high for exactly one cycle only if that enable and irq_mask_en are both 1.
- R8: An acknowledge pulse returns irq_flag_n to 1.
- R9: Each accepted dma_step moves n words, one per cycle on dst_we. n is 256 when byte_count exceeds 512. Otherwise n is (byte_count+1)/2 and the step is the last one. Exactly one step runs per request.
- R10: A step advances buf_addr by 2n, modulo 2^16. A non-last step lowers byte_count by 2n. A last step sets byte_count to 0 and performs the end actions of R6 and R7.
- R11: Destination byte address for word k of a step is computed from dma_adr and the target:
  - program memory (dest_sel=5): dma_adr[15:0]*8 + 2k, with dst_work=0;
  - work memory, full bank (dest_sel=7, half_bank=0): dma_adr[14:0]*8 + 2k, with dst_work=1;
  - work memory, half bank (dest_sel=7, half_bank=1): dma_adr[13:0]*16 + 4k, plus 2 when bank_sel=0, with dst_work=1.
- R12: dest_sel=4 is a discard sink. Its steps advance the count and address as in R9 and R10 but never assert dst_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_xfer_en | input | 1 | Transfer-enable value written by ctl_wr |
| ctl_end_irq_en | input | 1 | End-interrupt enable value written by ctl_wr |
| cnt_wr | input | 1 | Load byte count |
| cnt_wdata | input | 16 | Byte count load value |
| src_wr | input | 1 | Load source address |
| src_wdata | input | 16 | Source address load value |
| xfer_trig | input | 1 | Start trigger |
| irq_ack | input | 1 | End-interrupt acknowledge |
| rdy_set | input | 1 | Sets the data-ready flag |
| dest_sel | input | 3 | Destination code (2 main, 3 sub, 4 discard, 5 program, 7 work) |
| half_bank | input | 1 | Work memory in half-bank layout |
| bank_sel | input | 1 | Half-bank select |
| dma_adr | input | 16 | DMA destination base |
| rd_main | input | 1 | Main processor word read strobe |
| rd_sub | input | 1 | Sub processor word read strobe |
| irq_mask_en | input | 1 | Interrupt mask enable for the request |
| dma_step | input | 1 | DMA step request |
| buf_addr | output | 16 | Buffer byte address (source address) |
| buf_b0 | input | 8 | Buffer byte at buf_addr |
| buf_b1 | input | 8 | Buffer byte at buf_addr+1 |
| host_data | output | 16 | Word returned by the last host read |
| dst_we | output | 1 | Destination write strobe |
| dst_work | output | 1 | 1: work memory, 0: program memory |
| dst_addr | output | 19 | Destination byte address |
| dst_data | output | 16 | Destination write data |
| byte_count | output | 16 | Remaining byte count |
| busy_n | output | 1 | Active-low transfer in progress |
| irq_flag_n | output | 1 | Active-low end-of-transfer interrupt flag |
| end_flag | output | 1 | Transfer ended |
| data_ready | output | 1 | Data-ready flag |
| xfer_active | output | 1 | Transfer active |
| irq_req | output | 1 | One-cycle interrupt request |

## Verification
The hardest state to reach is a last DMA step that follows full-size steps. It needs a count above 512 that has been drained by two steps of 256 words. On top of that, the source address has to cross the 16-bit wrap during the same transfer. The bench loads a count of 1030 bytes and a source of 0xFFFC, then issues three separate step requests. It checks the intermediate counts, the idle gap between requests and the wrapped final address. Address formation per target is walked from a vector table, including an all-ones base that exposes the dropped high bits.

// File: rtl/sxe_pkg.sv
package sxe_pkg;
  localparam logic [2:0] DSEL_MAIN    = 3'd2;
  localparam logic [2:0] DSEL_SUB     = 3'd3;
  localparam logic [2:0] DSEL_DISCARD = 3'd4;
  localparam logic [2:0] DSEL_PROG    = 3'd5;
  localparam logic [2:0] DSEL_WORK    = 3'd7;

  typedef enum logic [2:0] {
    TGT_NONE    = 3'd0,
    TGT_DISCARD = 3'd1,
    TGT_PROG    = 3'd2,
    TGT_WFULL   = 3'd3,
    TGT_WHALF   = 3'd4
  } tgt_e;

  function automatic tgt_e decode_target(input logic [2:0] sel, input logic half);
    tgt_e t;
    case (sel)
      DSEL_DISCARD: t = TGT_DISCARD;
      DSEL_PROG:    t = TGT_PROG;
      DSEL_WORK:    t = half ? TGT_WHALF : TGT_WFULL;
      default:      t = TGT_NONE;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/sxe_host_port.sv
module sxe_host_port
  import sxe_pkg::*;
(
  input  logic        xfer_active,
  input  logic [2:0]  dest_sel,
  input  logic        rd_main,
  input  logic        rd_sub,
  input  logic [7:0]  byte_even,
  input  logic [7:0]  byte_odd,
  output logic        rd_strobe,
  output logic        rd_ok,
  output logic [15:0] rd_word
);
  // A read is honoured only when the requesting side matches the code.
  function automatic logic side_match(input logic [2:0] sel, input logic m, input logic s);
    return (s && sel == DSEL_SUB) || (m && sel == DSEL_MAIN);
  endfunction

  assign rd_strobe = rd_main | rd_sub;
  assign rd_ok     = xfer_active && side_match(dest_sel, rd_main, rd_sub);
  assign rd_word   = {byte_even, byte_odd};
endmodule

// File: rtl/sxe_dma_stepper.sv
module sxe_dma_stepper #(
  parameter  int CNT_W     = 16,
  parameter  int MAX_WORDS = 256,
  localparam int STEP_W    = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [CNT_W-1:0]  count,
  output logic              run,
  output logic [STEP_W-1:0] word_idx,
  output logic              done,
  output logic              done_last,
  output logic [STEP_W-1:0] done_words
);
  localparam int LAST_LIMIT = 2 * MAX_WORDS;

  function automatic logic is_last(input logic [CNT_W-1:0] c);
    return int'(c) <= LAST_LIMIT;
  endfunction

  function automatic logic [STEP_W-1:0] plan_words(input logic [CNT_W-1:0] c);
    logic [CNT_W:0] halfc;
    halfc = ({1'b0, c} + 1'b1) >> 1;
    if (is_last(c)) return STEP_W'(halfc);
    return STEP_W'(MAX_WORDS);
  endfunction

  logic              busy_q, last_q;
  logic [STEP_W-1:0] n_q, idx_q;
  logic [STEP_W-1:0] plan;
  logic              zero_step, final_word;

  assign plan       = plan_words(count);
  assign zero_step  = start && (plan == '0);
  assign final_word = busy_q && (idx_q == n_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      last_q <= 1'b0;
      n_q    <= '0;
      idx_q  <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
    end else if (start && !zero_step) begin
      busy_q <= 1'b1;
      n_q    <= plan;
      idx_q  <= '0;
      last_q <= is_last(count);
    end else if (busy_q) begin
      if (final_word) busy_q <= 1'b0;
      else            idx_q  <= idx_q + 1'b1;
    end
  end

  assign run        = busy_q;
  assign word_idx   = idx_q;
  assign done       = !abort && (zero_step || final_word);
  assign done_last  = zero_step || last_q;
  assign done_words = zero_step ? '0 : n_q;
endmodule

// File: rtl/sxe_dst_addr.sv
module sxe_dst_addr
  import sxe_pkg::*;
#(
  parameter  int DMA_W  = 16,
  parameter  int STEP_W = 9,
  localparam int DST_AW = DMA_W + 3
) (
  input  tgt_e              tgt,
  input  logic [DMA_W-1:0]  base,
  input  logic              bank_sel,
  input  logic [STEP_W-1:0] idx,
  output logic [DST_AW-1:0] addr
);
  function automatic logic [DST_AW-1:0] prog_addr(input logic [DMA_W-1:0] b, input logic [STEP_W-1:0] k);
    return {b, 3'b000} + (DST_AW'(k) << 1);
  endfunction

  function automatic logic [DST_AW-1:0] wfull_addr(input logic [DMA_W-1:0] b, input logic [STEP_W-1:0] k);
    return DST_AW'({b[DMA_W-2:0], 3'b000}) + (DST_AW'(k) << 1);
  endfunction

  function automatic logic [DST_AW-1:0] whalf_addr(input logic [DMA_W-1:0] b, input logic bs,
                                                   input logic [STEP_W-1:0] k);
    logic [DST_AW-1:0] lane;
    lane = bs ? '0 : DST_AW'(2);
    return DST_AW'({b[DMA_W-3:0], 4'b0000}) + lane + (DST_AW'(k) << 2);
  endfunction

  always_comb begin
    case (tgt)
      TGT_PROG:  addr = prog_addr(base, idx);
      TGT_WFULL: addr = wfull_addr(base, idx);
      TGT_WHALF: addr = whalf_addr(base, bank_sel, idx);
      default:   addr = '0;
    endcase
  end
endmodule

// File: rtl/sxe_engine.sv
module sxe_engine
  import sxe_pkg::*;
#(
  parameter  int CNT_W     = 16,
  parameter  int SRC_W     = 16,
  parameter  int DMA_W     = 16,
  parameter  int MAX_WORDS = 256,
  localparam int DST_AW    = DMA_W + 3,
  localparam int STEP_W    = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_xfer_en,
  input  logic              ctl_end_irq_en,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              src_wr,
  input  logic [SRC_W-1:0]  src_wdata,
  input  logic              xfer_trig,
  input  logic              irq_ack,
  input  logic              rdy_set,
  input  logic [2:0]        dest_sel,
  input  logic              half_bank,
  input  logic              bank_sel,
  input  logic [DMA_W-1:0]  dma_adr,
  input  logic              rd_main,
  input  logic              rd_sub,
  input  logic              irq_mask_en,
  input  logic              dma_step,
  output logic [SRC_W-1:0]  buf_addr,
  input  logic [7:0]        buf_b0,
  input  logic [7:0]        buf_b1,
  output logic [15:0]       host_data,
  output logic              dst_we,
  output logic              dst_work,
  output logic [DST_AW-1:0] dst_addr,
  output logic [15:0]       dst_data,
  output logic [CNT_W-1:0]  byte_count,
  output logic              busy_n,
  output logic              irq_flag_n,
  output logic              end_flag,
  output logic              data_ready,
  output logic              xfer_active,
  output logic              irq_req
);
  // Stored control bits
  logic xfer_en_q, end_irq_en_q;

  // State registers
  logic [CNT_W-1:0] count_q;
  logic [SRC_W-1:0] src_q;
  logic             active_q, busy_n_q, irq_n_q, end_q, rdy_q, irq_req_q;
  logic [15:0]      host_q;

  // Captured step context
  tgt_e             tgt_q;
  logic [DMA_W-1:0] base_q;
  logic             bank_q;

  // Named internal events
  logic              abort_evt, start_evt, end_evt;
  logic              rd_strobe, rd_ok, rd_end;
  logic [15:0]       rd_word;
  logic              step_ok, step_start, run, step_done, step_last;
  logic [STEP_W-1:0] step_idx, step_words;
  tgt_e              tgt_now;

  function automatic logic [CNT_W-1:0] cnt_after_step(input logic [CNT_W-1:0] c,
                                                     input logic [STEP_W-1:0] n);
    return c - (CNT_W'(n) << 1);
  endfunction

  sxe_host_port u_host (
    .xfer_active (active_q),
    .dest_sel    (dest_sel),
    .rd_main     (rd_main),
    .rd_sub      (rd_sub),
    .byte_even   (buf_b0),
    .byte_odd    (buf_b1),
    .rd_strobe   (rd_strobe),
    .rd_ok       (rd_ok),
    .rd_word     (rd_word)
  );

  assign tgt_now    = decode_target(dest_sel, half_bank);
  assign step_ok    = active_q && (tgt_now != TGT_NONE);
  assign abort_evt  = ctl_wr && !ctl_xfer_en;
  assign step_start = dma_step && step_ok && !run && !abort_evt;

  sxe_dma_stepper #(.CNT_W(CNT_W), .MAX_WORDS(MAX_WORDS)) u_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (step_start),
    .abort      (abort_evt),
    .count      (count_q),
    .run        (run),
    .word_idx   (step_idx),
    .done       (step_done),
    .done_last  (step_last),
    .done_words (step_words)
  );

  sxe_dst_addr #(.DMA_W(DMA_W), .STEP_W(STEP_W)) u_addr (
    .tgt      (tgt_q),
    .base     (base_q),
    .bank_sel (bank_q),
    .idx      (step_idx),
    .addr     (dst_addr)
  );

  assign start_evt = xfer_trig && xfer_en_q && !abort_evt;
  assign rd_end    = rd_ok && (int'(count_q) <= 2);
  assign end_evt   = !abort_evt && (rd_end || (step_done && step_last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_en_q    <= 1'b0;
      end_irq_en_q <= 1'b0;
    end else if (ctl_wr) begin
      xfer_en_q    <= ctl_xfer_en;
      end_irq_en_q <= ctl_end_irq_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (abort_evt) begin
      count_q <= '0;
    end else if (cnt_wr) begin
      count_q <= cnt_wdata;
    end else if (end_evt) begin
      count_q <= '0;
    end else if (rd_ok) begin
      count_q <= count_q - CNT_W'(2);
    end else if (step_done) begin
      count_q <= cnt_after_step(count_q, step_words);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              src_q <= '0;
    else if (src_wr)         src_q <= src_wdata;
    else if (rd_ok || run)   src_q <= src_q + SRC_W'(2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      busy_n_q <= 1'b1;
      end_q    <= 1'b0;
    end else if (abort_evt) begin
      active_q <= 1'b0;
      busy_n_q <= 1'b1;
    end else if (start_evt) begin
      active_q <= 1'b1;
      busy_n_q <= 1'b0;
      end_q    <= 1'b0;
    end else if (end_evt) begin
      active_q <= 1'b0;
      busy_n_q <= 1'b1;
      end_q    <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q     <= 1'b0;
      irq_n_q   <= 1'b1;
      irq_req_q <= 1'b0;
    end else begin
      if (end_evt)      rdy_q <= 1'b0;
      else if (rdy_set) rdy_q <= 1'b1;
      if (end_evt && end_irq_en_q) irq_n_q <= 1'b0;
      else if (irq_ack)            irq_n_q <= 1'b1;
      irq_req_q <= end_evt && end_irq_en_q && irq_mask_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         host_q <= '0;
    else if (rd_strobe) host_q <= rd_ok ? rd_word : 16'h0000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= TGT_NONE;
      base_q <= '0;
      bank_q <= 1'b0;
    end else if (step_start) begin
      tgt_q  <= tgt_now;
      base_q <= dma_adr;
      bank_q <= bank_sel;
    end
  end

  assign buf_addr    = src_q;
  assign host_data   = host_q;
  assign dst_we      = run && (tgt_q != TGT_DISCARD) && (tgt_q != TGT_NONE);
  assign dst_work    = (tgt_q == TGT_WFULL) || (tgt_q == TGT_WHALF);
  assign dst_data    = {buf_b0, buf_b1};
  assign byte_count  = count_q;
  assign busy_n      = busy_n_q;
  assign irq_flag_n  = irq_n_q;
  assign end_flag    = end_q;
  assign data_ready  = rdy_q;
  assign xfer_active = active_q;
  assign irq_req     = irq_req_q;
endmodule

// File: rtl/sxe_engine_chk.sv
module sxe_engine_chk #(
  parameter int CNT_W  = 16,
  parameter int SRC_W  = 16,
  parameter int STEP_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_evt,
  input logic              abort_evt,
  input logic              end_evt,
  input logic              rd_strobe,
  input logic              rd_ok,
  input logic              run,
  input logic              step_done,
  input logic              step_last,
  input logic [STEP_W-1:0] step_words,
  input logic              cnt_wr,
  input logic              src_wr,
  input logic              irq_ack,
  input logic [CNT_W-1:0]  byte_count,
  input logic [SRC_W-1:0]  buf_addr,
  input logic [15:0]       host_data,
  input logic              busy_n,
  input logic              irq_flag_n,
  input logic              end_flag,
  input logic              xfer_active,
  input logic              irq_req
);
  a_r1_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !irq_flag_n);

  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> xfer_active && !busy_n && !end_flag);

  a_r3_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> byte_count == '0 && !xfer_active && busy_n);

  a_r4_refused_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !rd_ok && !cnt_wr && !abort_evt && !step_done)
      |=> host_data == 16'h0000 && byte_count == $past(byte_count));

  a_r5_read_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && !src_wr) |=> buf_addr == $past(buf_addr) + SRC_W'(2));

  a_r6_end_state: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt && !start_evt) |=> !xfer_active && end_flag && busy_n && byte_count == '0);

  a_r8_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !end_evt) |=> irq_flag_n);

  a_r9_run_only_active: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> xfer_active);

  a_r10_step_count: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && !step_last && !cnt_wr && !abort_evt)
      |=> byte_count == $past(byte_count) - (CNT_W'($past(step_words)) << 1));
endmodule

bind sxe_engine sxe_engine_chk #(.CNT_W(CNT_W), .SRC_W(SRC_W), .STEP_W(STEP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_evt   (start_evt),
  .abort_evt   (abort_evt),
  .end_evt     (end_evt),
  .rd_strobe   (rd_strobe),
  .rd_ok       (rd_ok),
  .run         (run),
  .step_done   (step_done),
  .step_last   (step_last),
  .step_words  (step_words),
  .cnt_wr      (cnt_wr),
  .src_wr      (src_wr),
  .irq_ack     (irq_ack),
  .byte_count  (byte_count),
  .buf_addr    (buf_addr),
  .host_data   (host_data),
  .busy_n      (busy_n),
  .irq_flag_n  (irq_flag_n),
  .end_flag    (end_flag),
  .xfer_active (xfer_active),
  .irq_req     (irq_req)
);

// File: tb/sxe_engine_tb_top.sv
module sxe_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 0, ctl_xfer_en = 0, ctl_end_irq_en = 0;
  logic        cnt_wr = 0;
  logic [15:0] cnt_wdata = '0;
  logic        src_wr = 0;
  logic [15:0] src_wdata = '0;
  logic        xfer_trig = 0, irq_ack = 0, rdy_set = 0;
  logic [2:0]  dest_sel = 3'd0;
  logic        half_bank = 0, bank_sel = 0;
  logic [15:0] dma_adr = '0;
  logic        rd_main = 0, rd_sub = 0, irq_mask_en = 0, dma_step = 0;
  logic [15:0] buf_addr;
  logic [7:0]  buf_b0, buf_b1;
  logic [15:0] host_data;
  logic        dst_we, dst_work;
  logic [18:0] dst_addr;
  logic [15:0] dst_data;
  logic [15:0] byte_count;
  logic        busy_n, irq_flag_n, end_flag, data_ready, xfer_active, irq_req;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] bval(input logic [15:0] a);
    return (a[7:0] ^ a[15:8]) * 8'd7 + 8'd3;
  endfunction

  assign buf_b0 = bval(buf_addr);
  assign buf_b1 = bval(buf_addr + 16'd1);

  sxe_engine dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_xfer_en(ctl_xfer_en),
    .ctl_end_irq_en(ctl_end_irq_en), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .src_wr(src_wr), .src_wdata(src_wdata), .xfer_trig(xfer_trig), .irq_ack(irq_ack),
    .rdy_set(rdy_set), .dest_sel(dest_sel), .half_bank(half_bank), .bank_sel(bank_sel),
    .dma_adr(dma_adr), .rd_main(rd_main), .rd_sub(rd_sub), .irq_mask_en(irq_mask_en),
    .dma_step(dma_step), .buf_addr(buf_addr), .buf_b0(buf_b0), .buf_b1(buf_b1),
    .host_data(host_data), .dst_we(dst_we), .dst_work(dst_work), .dst_addr(dst_addr),
    .dst_data(dst_data), .byte_count(byte_count), .busy_n(busy_n), .irq_flag_n(irq_flag_n),
    .end_flag(end_flag), .data_ready(data_ready), .xfer_active(xfer_active), .irq_req(irq_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic set_ctl(input logic en, input logic ie);
    ctl_wr = 1; ctl_xfer_en = en; ctl_end_irq_en = ie;
    tick;
    ctl_wr = 0;
  endtask

  task automatic load(input logic [15:0] c, input logic [15:0] s);
    cnt_wr = 1; cnt_wdata = c; src_wr = 1; src_wdata = s;
    tick;
    cnt_wr = 0; src_wr = 0;
  endtask

  task automatic start;
    xfer_trig = 1;
    tick;
    xfer_trig = 0;
  endtask

  task automatic host_read(input logic sub);
    if (sub) rd_sub = 1; else rd_main = 1;
    tick;
    rd_sub = 0; rd_main = 0;
  endtask

  // One step request; returns words written and first address.
  task automatic dma_once(output int nw, output logic [18:0] first, output logic [18:0] second);
    nw = 0; first = '0; second = '0;
    dma_step = 1;
    tick;
    dma_step = 0;
    while (dst_we && nw < 400) begin
      if (nw == 0) first = dst_addr;
      if (nw == 1) second = dst_addr;
      nw++;
      tick;
    end
  endtask

  // Address formation vectors
  localparam int NV = 5;
  localparam logic [2:0]  V_SEL  [NV] = '{3'd5, 3'd7, 3'd7, 3'd7, 3'd5};
  localparam logic        V_HALF [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic        V_BANK [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic [15:0] V_DMA  [NV] = '{16'h1234, 16'hFFFF, 16'h4001, 16'h0003, 16'hFFFF};
  localparam logic [18:0] V_EXP  [NV] = '{19'h091A0, 19'h3FFF8, 19'h00012, 19'h00030, 19'h7FFF8};
  localparam logic        V_WORK [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0};

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int nw;
    logic [18:0] fa, sa;
    int seen;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick;
    // R1 reset state
    chk("R1 busy_n", busy_n, 1);
    chk("R1 irq_flag_n", irq_flag_n, 1);
    chk("R1 end_flag", end_flag, 0);
    chk("R1 active", xfer_active, 0);
    chk("R1 count", byte_count, 0);
    chk("R1 irq_req", irq_req, 0);
    chk("R1 dst_we", dst_we, 0);

    // R2 start refused without enable
    load(16'd5, 16'h0010);
    start;
    chk("R2 no start active", xfer_active, 0);
    chk("R2 no start busy_n", busy_n, 1);
    set_ctl(1, 1);
    start;
    chk("R2 start active", xfer_active, 1);
    chk("R2 start busy_n", busy_n, 0);
    chk("R2 end_flag low", end_flag, 0);

    // R5 and R4 host reads
    dest_sel = 3'd3;
    rdy_set = 1; tick; rdy_set = 0;
    host_read(1);
    chk("R5 word", host_data, {bval(16'h0010), bval(16'h0011)});
    chk("R5 count", byte_count, 3);
    chk("R5 addr", buf_addr, 16'h0012);
    host_read(0);
    chk("R4 wrong side data", host_data, 0);
    chk("R4 wrong side count", byte_count, 3);
    chk("R4 wrong side addr", buf_addr, 16'h0012);
    host_read(1);
    chk("R5 count 1", byte_count, 1);
    chk("R6 not yet ended", xfer_active, 1);
    irq_mask_en = 1;
    host_read(1);
    // R6 end on a count of 1
    chk("R6 word still returned", host_data, {bval(16'h0014), bval(16'h0015)});
    chk("R6 count", byte_count, 0);
    chk("R6 active", xfer_active, 0);
    chk("R6 end_flag", end_flag, 1);
    chk("R6 data_ready", data_ready, 0);
    chk("R6 busy_n", busy_n, 1);
    chk("R7 flag low", irq_flag_n, 0);
    chk("R7 req pulse", irq_req, 1);
    tick;
    chk("R7 req one cycle", irq_req, 0);
    irq_ack = 1; tick; irq_ack = 0;
    chk("R8 ack", irq_flag_n, 1);
    host_read(1);
    chk("R4 inactive read", host_data, 0);

    // R4 main side with code 2
    dest_sel = 3'd2;
    load(16'd4, 16'h0200);
    start;
    host_read(0);
    chk("R4 main honoured", host_data, {bval(16'h0200), bval(16'h0201)});

    // R3 abort
    load(16'd100, 16'h0300);
    set_ctl(0, 1);
    chk("R3 count", byte_count, 0);
    chk("R3 active", xfer_active, 0);
    chk("R3 busy_n", busy_n, 1);

    // R11 address vectors
    set_ctl(1, 0);
    irq_mask_en = 0;
    for (int v = 0; v < NV; v++) begin
      dest_sel = V_SEL[v]; half_bank = V_HALF[v]; bank_sel = V_BANK[v]; dma_adr = V_DMA[v];
      load(16'd6, 16'h0100);
      start;
      dma_once(nw, fa, sa);
      chk("R11 first addr", fa, V_EXP[v]);
      chk("R11 stride", sa - fa, V_HALF[v] ? 4 : 2);
      chk("R11 work select", dst_work, V_WORK[v]);
      chk("R9 words", nw, 3);
      chk("R10 end", end_flag, 1);
    end

    // R9 R10 multi step with address wrap
    dest_sel = 3'd5; half_bank = 0; dma_adr = 16'h0010;
    load(16'd1030, 16'hFFFC);
    start;
    dma_once(nw, fa, sa);
    chk("R9 step1 words", nw, 256);
    chk("R10 step1 count", byte_count, 518);
    chk("R10 still active", xfer_active, 1);
    repeat (10) tick;
    chk("R9 one step per request", byte_count, 518);
    dma_once(nw, fa, sa);
    chk("R9 step2 words", nw, 256);
    chk("R10 step2 count", byte_count, 6);
    dma_once(nw, fa, sa);
    chk("R9 last words", nw, 3);
    chk("R10 last count", byte_count, 0);
    chk("R10 wrapped addr", buf_addr, 16'h0402);
    chk("R10 end flag", end_flag, 1);
    chk("R10 busy_n", busy_n, 1);
    chk("R7 flag kept without enable", irq_flag_n, 1);

    // R9 odd count rounds up
    load(16'd7, 16'h0000);
    start;
    dma_once(nw, fa, sa);
    chk("R9 odd words", nw, 4);
    chk("R9 odd ended", xfer_active, 0);

    // R9 zero count ends at once
    load(16'd0, 16'h0040);
    start;
    dma_once(nw, fa, sa);
    chk("R9 zero words", nw, 0);
    chk("R9 zero ended", end_flag, 1);
    chk("R9 zero addr", buf_addr, 16'h0040);

    // R12 discard sink; R7 with mask off
    set_ctl(1, 1);
    irq_mask_en = 0;
    dest_sel = 3'd4;
    load(16'd10, 16'h0500);
    start;
    dma_step = 1; tick; dma_step = 0;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      if (dst_we) seen++;
      if (irq_req) seen += 100;
      tick;
    end
    chk("R12 no writes / R7 no req", seen, 0);
    chk("R12 count", byte_count, 0);
    chk("R12 addr", buf_addr, 16'h050A);
    chk("R12 ended", end_flag, 1);
    chk("R7 flag without mask", irq_flag_n, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule